// File: doc/BRIEF.md
# Segment Descriptor Fetch Unit

This unit fills a hidden segment cache from an 8-byte segment descriptor held in memory. A client offers a 16-bit selector and a flag that says whether the target register is a data or stack segment register. The unit splits the selector into a table index, a table pick and a requested privilege. It checks the index against the limit of the selected table and computes the byte address of the descriptor. It then reads the eight bytes one at a time over a byte-wide read port with a data-valid strobe.

When the last byte arrives, the unit puts the scattered base and limit pieces back together. It extracts the access byte, granularity and default-size bits, and sorts the descriptor into one of four classes: code/data, local table, task state or gate. It then either updates the cache in one step and pulses done, or leaves the cache untouched and pulses fault with a reason code. A selector that names entry zero of the global table loads an empty, not-present entry without any memory traffic.

Top module: `desc_loader`

## Requirements
- R1: While reset is held, `load_rdy_o` is 1, `done_o`, `fault_o` and `mem_req_o` are 0, and every cache output is 0.
- R2: Selector bits 15:3 are the index and bit 2 picks the table (0 = global, 1 = local). The eight reads go to base + index*8 + 0 through + 7, in ascending order, where base is the base of the picked table.
- R3: If index*8+7 is greater than the picked table's limit, the unit issues no read and reports `fault_o` with code 1. The cache keeps its previous contents.
- R4: Index 0 with bit 2 = 0 issues no read and reports `done_o`. All cache fields then read zero, so `cache_present_o` is 0 and `cache_sel_o` is the selector. Index 0 of the local table is fetched normally.
- R5: With descriptor bytes b0..b7 in read order, a successful load gives base = {b7,b4,b3,b2}, limit = {b6[3:0],b1,b0}, access = b5, granularity = b6[7], default size = b6[6], present = b5[7] and `cache_sel_o` = selector.
- R6: One byte is taken for each cycle in which `mem_req_o` and `mem_valid_i` are both high. While `mem_valid_i` is low, `mem_addr_o` and `mem_req_o` hold.
- R7: The cache outputs change only in the cycle in which `done_o` is high. A fault leaves all of them unchanged.
- R8: A descriptor with access bit 4 = 0 (a system descriptor), loaded while `tgt_data_i` = 1, faults with code 2.
- R9: A system descriptor whose type (access bits 3:0) is 0, 8, 10 or 13 faults with code 2, whatever the value of `tgt_data_i`.
- R10: If no type fault applies and b6 bits 5:4 are not both zero, the load faults with code 3.
- R11: `cache_class_o` is 0 for a code/data descriptor (access bit 4 = 1). For a system descriptor it is 1 for type 2, 2 for types 1, 3, 9 and 11, and 3 for types 4, 5, 6, 7, 12, 14 and 15.
- R12: A load is accepted when `load_req_i` is high while `load_rdy_o` is high. `load_rdy_o` stays low from acceptance until the cycle after the result. `done_o` and `fault_o` are never high together, each is a single-cycle pulse, and `fault_code_o` is 0 except when `fault_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_req_i | input | 1 | Load request |
| selector_i | input | 16 | Selector to load |
| tgt_data_i | input | 1 | Target is a data/stack segment register |
| load_rdy_o | output | 1 | Unit idle and able to accept a request |
| gdt_base_i | input | 32 | Global table base address |
| gdt_limit_i | input | 16 | Global table limit (last valid byte offset) |
| ldt_base_i | input | 32 | Local table base address |
| ldt_limit_i | input | 16 | Local table limit (last valid byte offset) |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Byte read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data byte |
| done_o | output | 1 | Load completed, cache updated |
| fault_o | output | 1 | Load rejected |
| fault_code_o | output | 2 | 0 none, 1 table limit, 2 type, 3 format |
| cache_base_o | output | 32 | Cached segment base |
| cache_limit_o | output | 20 | Cached segment limit |
| cache_access_o | output | 8 | Cached access byte |
| cache_present_o | output | 1 | Cached present bit |
| cache_gran_o | output | 1 | Cached granularity bit |
| cache_dsize_o | output | 1 | Cached default-size bit |
| cache_class_o | output | 2 | Cached descriptor class |
| cache_sel_o | output | 16 | Selector of the cached entry |

## Verification
The assertions assume that the memory side raises `mem_valid_i` only while `mem_req_o` is high, and that the table base and limit inputs stay constant for the whole of a load. The bench memory model raises the strobe only in cycles where it sees a pending request, and it inserts stall cycles in a repeating pattern. The bench changes the table registers only between loads, while the unit is idle. Requests go out only while `load_rdy_o` is high, and each is withdrawn the cycle after it is accepted.

// File: rtl/desc_pkg.sv
package desc_pkg;
  localparam int DESC_BYTES = 8;
  localparam int SEG_LIM_W  = 20;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_TYPE   = 2'd2,
    FLT_FORMAT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    CLS_SEG  = 2'd0,
    CLS_LDT  = 2'd1,
    CLS_TSS  = 2'd2,
    CLS_GATE = 2'd3
  } class_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } state_e;
endpackage

// File: rtl/desc_sel_decode.sv
module desc_sel_decode #(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [SEL_W-1:0]  gdt_limit_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [SEL_W-1:0]  ldt_limit_i,
  output logic              is_null_o,
  output logic              over_limit_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int IDX_W = SEL_W - 3;

  logic [IDX_W-1:0]  idx;
  logic              use_ldt;
  logic [SEL_W-1:0]  first_off, last_off, tbl_lim;
  logic [ADDR_W-1:0] tbl_base;

  assign idx       = sel_i[SEL_W-1:3];
  assign use_ldt   = sel_i[2];
  assign first_off = {idx, 3'b000};
  assign last_off  = {idx, 3'b111};
  assign tbl_base  = use_ldt ? ldt_base_i  : gdt_base_i;
  assign tbl_lim   = use_ldt ? ldt_limit_i : gdt_limit_i;

  assign is_null_o    = (idx == '0) && !use_ldt;
  assign over_limit_o = last_off > tbl_lim;
  assign addr_o       = tbl_base + ADDR_W'(first_off);
endmodule

// File: rtl/desc_byte_buf.sv
module desc_byte_buf
  import desc_pkg::*;
#(
  parameter int CNT_W = $clog2(DESC_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [CNT_W-1:0]        pos_i,
  input  logic [7:0]              data_i,
  output logic [DESC_BYTES*8-1:0] raw_o
);
  // last byte is passed through live so the cache can load on its arrival
  for (genvar g = 0; g < DESC_BYTES - 1; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            byte_q <= '0;
      else if (wr_i && pos_i == CNT_W'(g))    byte_q <= data_i;
    end
    assign raw_o[8*g +: 8] = byte_q;
  end
  assign raw_o[8*(DESC_BYTES-1) +: 8] = data_i;
endmodule

// File: rtl/desc_classify.sv
module desc_classify
  import desc_pkg::*;
(
  input  logic [DESC_BYTES*8-1:0] raw_i,
  input  logic                    tgt_data_i,
  output logic [31:0]             base_o,
  output logic [SEG_LIM_W-1:0]    limit_o,
  output logic [7:0]              access_o,
  output logic                    gran_o,
  output logic                    dsize_o,
  output class_e                  cls_o,
  output fault_e                  fault_o
);
  logic [7:0] b [DESC_BYTES];
  logic       is_sys, reserved;
  logic [3:0] typ;

  for (genvar g = 0; g < DESC_BYTES; g++) begin : g_split
    assign b[g] = raw_i[8*g +: 8];
  end

  assign base_o   = {b[7], b[4], b[3], b[2]};
  assign limit_o  = {b[6][3:0], b[1], b[0]};
  assign access_o = b[5];
  assign gran_o   = b[6][7];
  assign dsize_o  = b[6][6];
  assign is_sys   = !b[5][4];
  assign typ      = b[5][3:0];

  always_comb begin
    reserved = 1'b0;
    unique case (typ)
      4'd0, 4'd8, 4'd10, 4'd13: reserved = 1'b1;
      default:                  reserved = 1'b0;
    endcase
  end

  always_comb begin
    if (!is_sys) begin
      cls_o = CLS_SEG;
    end else begin
      unique case (typ)
        4'd2:                     cls_o = CLS_LDT;
        4'd1, 4'd3, 4'd9, 4'd11:  cls_o = CLS_TSS;
        default:                  cls_o = CLS_GATE;
      endcase
    end
  end

  always_comb begin
    if (is_sys && (tgt_data_i || reserved)) fault_o = FLT_TYPE;
    else if (b[6][5:4] != 2'b00)            fault_o = FLT_FORMAT;
    else                                    fault_o = FLT_NONE;
  end
endmodule

// File: rtl/desc_loader.sv
module desc_loader
  import desc_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_req_i,
  input  logic [SEL_W-1:0]     selector_i,
  input  logic                 tgt_data_i,
  output logic                 load_rdy_o,
  input  logic [ADDR_W-1:0]    gdt_base_i,
  input  logic [SEL_W-1:0]     gdt_limit_i,
  input  logic [ADDR_W-1:0]    ldt_base_i,
  input  logic [SEL_W-1:0]     ldt_limit_i,
  output logic                 mem_req_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic                 mem_valid_i,
  input  logic [7:0]           mem_data_i,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [1:0]           fault_code_o,
  output logic [31:0]          cache_base_o,
  output logic [SEG_LIM_W-1:0] cache_limit_o,
  output logic [7:0]           cache_access_o,
  output logic                 cache_present_o,
  output logic                 cache_gran_o,
  output logic                 cache_dsize_o,
  output logic [1:0]           cache_class_o,
  output logic [SEL_W-1:0]     cache_sel_o
);
  localparam int CNT_W = $clog2(DESC_BYTES);

  state_e              state_q;
  logic [SEL_W-1:0]    sel_q;
  logic                tgt_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                ok_q;
  fault_e              code_q;

  logic [31:0]          c_base_q;
  logic [SEG_LIM_W-1:0] c_limit_q;
  logic [7:0]           c_access_q;
  logic                 c_gran_q, c_dsize_q;
  class_e               c_class_q;
  logic [SEL_W-1:0]     c_sel_q;

  logic                 dec_null, dec_over;
  logic [ADDR_W-1:0]    dec_addr;
  logic                 accept, take, last;
  logic [DESC_BYTES*8-1:0] raw;
  logic [31:0]          f_base;
  logic [SEG_LIM_W-1:0] f_limit;
  logic [7:0]           f_access;
  logic                 f_gran, f_dsize;
  class_e               f_cls;
  fault_e               f_fault;

  desc_sel_decode #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_dec (
    .sel_i       (selector_i),
    .gdt_base_i  (gdt_base_i),
    .gdt_limit_i (gdt_limit_i),
    .ldt_base_i  (ldt_base_i),
    .ldt_limit_i (ldt_limit_i),
    .is_null_o   (dec_null),
    .over_limit_o(dec_over),
    .addr_o      (dec_addr)
  );

  desc_byte_buf #(.CNT_W(CNT_W)) u_buf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (take),
    .pos_i (cnt_q),
    .data_i(mem_data_i),
    .raw_o (raw)
  );

  desc_classify u_cls (
    .raw_i     (raw),
    .tgt_data_i(tgt_q),
    .base_o    (f_base),
    .limit_o   (f_limit),
    .access_o  (f_access),
    .gran_o    (f_gran),
    .dsize_o   (f_dsize),
    .cls_o     (f_cls),
    .fault_o   (f_fault)
  );

  assign accept = load_req_i && (state_q == ST_IDLE);
  assign take   = (state_q == ST_FETCH) && mem_valid_i;
  assign last   = take && (cnt_q == CNT_W'(DESC_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      tgt_q   <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      code_q  <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sel_q <= selector_i;
          tgt_q <= tgt_data_i;
          if (dec_null) begin
            ok_q    <= 1'b1;
            code_q  <= FLT_NONE;
            state_q <= ST_RESP;
          end else if (dec_over) begin
            ok_q    <= 1'b0;
            code_q  <= FLT_LIMIT;
            state_q <= ST_RESP;
          end else begin
            addr_q  <= dec_addr;
            cnt_q   <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (take) begin
          if (last) begin
            ok_q    <= (f_fault == FLT_NONE);
            code_q  <= f_fault;
            state_q <= ST_RESP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // cache is written in one step: null entry on accept, full entry on last byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_base_q   <= '0;
      c_limit_q  <= '0;
      c_access_q <= '0;
      c_gran_q   <= 1'b0;
      c_dsize_q  <= 1'b0;
      c_class_q  <= CLS_SEG;
      c_sel_q    <= '0;
    end else if (accept && dec_null) begin
      c_base_q   <= '0;
      c_limit_q  <= '0;
      c_access_q <= '0;
      c_gran_q   <= 1'b0;
      c_dsize_q  <= 1'b0;
      c_class_q  <= CLS_SEG;
      c_sel_q    <= selector_i;
    end else if (last && f_fault == FLT_NONE) begin
      c_base_q   <= f_base;
      c_limit_q  <= f_limit;
      c_access_q <= f_access;
      c_gran_q   <= f_gran;
      c_dsize_q  <= f_dsize;
      c_class_q  <= f_cls;
      c_sel_q    <= sel_q;
    end
  end

  assign load_rdy_o      = (state_q == ST_IDLE);
  assign mem_req_o       = (state_q == ST_FETCH);
  assign mem_addr_o      = addr_q + ADDR_W'(cnt_q);
  assign done_o          = (state_q == ST_RESP) && ok_q;
  assign fault_o         = (state_q == ST_RESP) && !ok_q;
  assign fault_code_o    = fault_o ? code_q : FLT_NONE;
  assign cache_base_o    = c_base_q;
  assign cache_limit_o   = c_limit_q;
  assign cache_access_o  = c_access_q;
  assign cache_present_o = c_access_q[7];
  assign cache_gran_o    = c_gran_q;
  assign cache_dsize_o   = c_dsize_q;
  assign cache_class_o   = c_class_q;
  assign cache_sel_o     = c_sel_q;
endmodule

// File: rtl/desc_loader_chk.sv
module desc_loader_chk #(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_req_i,
  input logic [SEL_W-3:0]  sel_hi_i,
  input logic              load_rdy_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic              done_o,
  input logic              fault_o,
  input logic [1:0]        fault_code_o,
  input logic [31:0]       cache_base_o,
  input logic [19:0]       cache_limit_o,
  input logic [7:0]        cache_access_o,
  input logic              cache_present_o
);
  AST_NULL_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_req_i && load_rdy_o && sel_hi_i == '0 |=> done_o && !cache_present_o && !mem_req_o); // R4

  AST_LIMIT_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && fault_code_o == 2'd1 |-> !$past(mem_req_o)); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R6

  AST_CACHE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(cache_base_o) && $stable(cache_limit_o) && $stable(cache_access_o)); // R7

  AST_RESULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o)); // R12

  AST_RESULT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o || fault_o |=> !done_o && !fault_o && load_rdy_o); // R12

  AST_BUSY_NO_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !load_rdy_o); // R12

  AST_CODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> fault_code_o == 2'd0); // R12
endmodule

bind desc_loader desc_loader_chk #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .load_req_i     (load_req_i),
  .sel_hi_i       (selector_i[SEL_W-1:2]),
  .load_rdy_o     (load_rdy_o),
  .mem_req_o      (mem_req_o),
  .mem_addr_o     (mem_addr_o),
  .mem_valid_i    (mem_valid_i),
  .done_o         (done_o),
  .fault_o        (fault_o),
  .fault_code_o   (fault_code_o),
  .cache_base_o   (cache_base_o),
  .cache_limit_o  (cache_limit_o),
  .cache_access_o (cache_access_o),
  .cache_present_o(cache_present_o)
);

// File: tb/desc_loader_bench.sv
`timescale 1ns/1ps
module desc_loader_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_req_i = 1'b0;
  logic [15:0] selector_i = '0;
  logic        tgt_data_i = 1'b0;
  logic        load_rdy_o;
  logic [31:0] gdt_base_i = 32'h0001_0000;
  logic [15:0] gdt_limit_i = 16'd255;
  logic [31:0] ldt_base_i = 32'hABC0_0203;
  logic [15:0] ldt_limit_i = 16'd255;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [7:0]  mem_data_i = '0;
  logic        done_o, fault_o;
  logic [1:0]  fault_code_o;
  logic [31:0] cache_base_o;
  logic [19:0] cache_limit_o;
  logic [7:0]  cache_access_o;
  logic        cache_present_o, cache_gran_o, cache_dsize_o;
  logic [1:0]  cache_class_o;
  logic [15:0] cache_sel_o;

  desc_loader u_desc_loader (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0, nbytes = 0, stall = 0;
  logic [31:0] exp_addr = '0;
  int          exp_n0 = 0;
  logic [7:0]  mem [0:1023];

  logic [31:0] e_base = '0;
  logic [19:0] e_lim = '0;
  logic [7:0]  e_acc = '0;
  logic        e_g = 1'b0, e_d = 1'b0;
  logic [1:0]  e_cls = '0;
  logic [15:0] e_sel = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // memory model: stalls one cycle in three; R2 R6 address checked every request cycle
  always @(negedge clk_i) begin
    if (mem_valid_i) nbytes++;
    if (mem_req_o) begin
      chk("R2 R6 addr", mem_addr_o, exp_addr + 32'(nbytes - exp_n0));
      stall++;
      mem_valid_i <= (stall % 3) != 0;
      mem_data_i  <= mem[mem_addr_o[9:0]];
    end else begin
      mem_valid_i <= 1'b0;
    end
  end

  function automatic logic [1:0] f_code(input logic [7:0] acc, input logic [7:0] b6, input logic tgt);
    logic sys = !acc[4];
    logic rsv = acc[3:0] inside {4'd0, 4'd8, 4'd10, 4'd13};
    if (sys && (tgt || rsv)) return 2'd2;
    if (b6[5:4] != 2'b00)    return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [1:0] f_cls(input logic [7:0] acc);
    if (acc[4]) return 2'd0;
    case (acc[3:0])
      4'd2:                    return 2'd1;
      4'd1, 4'd3, 4'd9, 4'd11: return 2'd2;
      default:                 return 2'd3;
    endcase
  endfunction

  task automatic do_load(input logic [15:0] sel, input logic tgt);
    logic [7:0]  b [8];
    logic [12:0] idx = sel[15:3];
    logic        null_e = (idx == 0) && !sel[2];
    logic [31:0] base = sel[2] ? ldt_base_i : gdt_base_i;
    logic [15:0] lim  = sel[2] ? ldt_limit_i : gdt_limit_i;
    logic [31:0] ea   = base + {16'd0, idx, 3'b000};
    logic [1:0]  ecode;
    int          ereads, w;
    string       tag;
    for (int j = 0; j < 8; j++) b[j] = mem[10'(ea + 32'(j))];
    if (null_e) begin
      ecode = 2'd0; ereads = 0; tag = "R4";
    end else if ({idx, 3'b111} > lim) begin
      ecode = 2'd1; ereads = 0; tag = "R3";
    end else begin
      ecode = f_code(b[5], b[6], tgt); ereads = 8;
      tag = (ecode == 2'd2) ? (tgt ? "R8" : "R9") : (ecode == 2'd3) ? "R10" : "R5";
    end
    exp_addr = ea;
    exp_n0   = nbytes;
    @(negedge clk_i);
    chk("R12 rdy before", load_rdy_o, 1);
    selector_i = sel; tgt_data_i = tgt; load_req_i = 1'b1;
    @(negedge clk_i);
    load_req_i = 1'b0;
    w = 0;
    while (!(done_o || fault_o) && w < 100) begin
      chk("R12 rdy busy", load_rdy_o, 0);
      @(negedge clk_i); w++;
    end
    chk({tag, " outcome"}, {done_o, fault_o, fault_code_o}, {ecode == 2'd0, ecode != 2'd0, ecode});
    if (ecode == 2'd0) begin
      if (null_e) begin
        e_base = '0; e_lim = '0; e_acc = '0; e_g = 0; e_d = 0; e_cls = 0;
      end else begin
        e_base = {b[7], b[4], b[3], b[2]};
        e_lim  = {b[6][3:0], b[1], b[0]};
        e_acc  = b[5]; e_g = b[6][7]; e_d = b[6][6]; e_cls = f_cls(b[5]);
      end
      e_sel = sel;
    end
    chk({tag, " R7 base"}, cache_base_o, e_base);
    chk({tag, " R7 limit"}, cache_limit_o, e_lim);
    chk({tag, " R7 access"}, {cache_access_o, cache_present_o, cache_gran_o, cache_dsize_o},
        {e_acc, e_acc[7], e_g, e_d});
    chk("R11 class", cache_class_o, e_cls);
    chk("R5 sel", cache_sel_o, e_sel);
    @(negedge clk_i);
    chk("R12 pulse", {done_o, fault_o, load_rdy_o, fault_code_o}, {3'b001, 2'b00});
    chk({tag, " reads"}, nbytes - exp_n0, ereads);
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = 8'(a * 7 + 3);
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 32; k++) begin
        logic [31:0] a0 = (t == 1 ? 32'h203 : 32'h0) + 32'(k * 8);
        logic [7:0]  d [8];
        logic        s = (t == 1) ? ~k[4] : k[4];
        d[0] = 8'(k * 37 + 5);
        d[1] = 8'(k * 11 + t * 3);
        d[2] = 8'(k * 29 + 1);
        d[3] = 8'(k * 7 + t * 90);
        d[4] = 8'(k * 13 + 2);
        d[5] = {1'b1, 2'(k), s, 4'(k)};
        d[6] = {k[0], k[1], (k % 7 == 3) ? 2'b10 : 2'b00, 4'(k * 3 + t)};
        d[7] = 8'(k * 53 + t * 17);
        for (int j = 0; j < 8; j++) mem[10'(a0 + 32'(j))] = d[j];
      end
    end
    repeat (3) @(negedge clk_i);
    chk("R1 reset ctl", {load_rdy_o, done_o, fault_o, mem_req_o, fault_code_o}, {4'b1000, 2'b00});
    chk("R1 reset cache", {cache_base_o, cache_limit_o, cache_access_o, cache_sel_o, cache_class_o,
        cache_present_o, cache_gran_o, cache_dsize_o}, '0);
    rst_ni = 1'b1;
    // sweep: both target kinds, both tables, every entry (covers R2 R4 R5 R8 R9 R10 R11)
    for (int p = 0; p < 2; p++)
      for (int t = 0; t < 2; t++)
        for (int k = 0; k < 32; k++)
          do_load({13'(k), 1'(t), 2'(k + p)}, 1'(p));
    // table limit boundaries (R3)
    @(negedge clk_i);
    gdt_limit_i = 16'd46;
    ldt_limit_i = 16'd31;
    do_load({13'd5, 1'b0, 2'd0}, 1'b0);
    do_load({13'd4, 1'b0, 2'd1}, 1'b0);
    do_load({13'd4, 1'b1, 2'd2}, 1'b0);
    do_load({13'd3, 1'b1, 2'd3}, 1'b0);
    do_load({13'd0, 1'b0, 2'd3}, 1'b1);
    summary();
    $finish;
  end
endmodule